// File: doc/BRIEF.md
# SPI Hold Gate

This block sits between the synchronized SPI slave pins and a serial slave core. It lets a bus master pause a transfer in the middle. A pause is requested by pulling the active-low hold input low while the chip is selected and the serial clock is low. While the pause lasts, clock edges and serial input are not passed to the core, so the core's bit position stays where it was, and the serial output is released to high impedance. The pause ends when the hold input returns high with the serial clock low. The transfer then continues from the bit at which it stopped.

The core sees the serial clock as single-cycle rise and fall pulses in the system clock domain. Each rise pulse carries the serial input sample taken at that edge. When chip select is raised, the core receives a reset pulse. If that happens during a pause, the paused transfer is abandoned and the next selection starts from a clean state. The serial output is presented as a data value together with an enable, so a pad can build the tri-state driver.

Top module: `spi_hold_gate`

## Requirements
- R1: While reset is asserted, core_sck_rise_o, core_sck_fall_o, core_si_o, so_oe_o and core_rst_o are all 0.
- R2: With chip select low (cs_n_i=0) and no pause active, each 0→1 change of sck_i gives one core_sck_rise_o pulse, one clock cycle long, on the following clock cycle. core_si_o takes the si_i value present at that change. Each 1→0 change of sck_i gives one core_sck_fall_o pulse in the same way. A rise pulse and a fall pulse are never high together.
- R3: A pause starts when hold_n_i=0, sck_i=0 and cs_n_i=0 are seen together. From the next cycle onward, so_oe_o is 0.
- R4: A change of hold_n_i seen while sck_i=1 neither starts nor ends a pause. It takes effect only once sck_i is seen low.
- R5: During a pause, sck_i changes produce no rise or fall pulses and core_si_o does not change.
- R6: A pause ends when hold_n_i=1 and sck_i=0 are seen together. From the next cycle, so_oe_o follows core_so_oe_i again.
- R7: After a pause ends, so_o shows the same bit it showed just before the pause. A byte paused at any bit position is exchanged in both directions with no bit lost or repeated.
- R8: A 0→1 change of cs_n_i drives core_rst_o high for RST_CYCLES cycles, starting the next cycle. It also ends any pause. A transfer that was paused at that moment is not resumed; the next selection starts at bit 0.
- R9: While cs_n_i=1, no rise or fall pulses reach the core and so_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Synchronized chip select, active low |
| sck_i | input | 1 | Synchronized serial clock level |
| si_i | input | IO_W | Synchronized serial input |
| hold_n_i | input | 1 | Synchronized pause request, active low |
| core_so_i | input | IO_W | Serial output data from the core |
| core_so_oe_i | input | 1 | Output enable from the core |
| core_sck_rise_o | output | 1 | Gated serial clock rise pulse to the core |
| core_sck_fall_o | output | 1 | Gated serial clock fall pulse to the core |
| core_si_o | output | IO_W | Serial input sample for the core, valid with the rise pulse |
| so_o | output | IO_W | Serial output data to the pad |
| so_oe_o | output | 1 | Serial output drive enable to the pad |
| core_rst_o | output | 1 | Reset pulse to the core on deselect |

## Verification
Suppose the pause state were set wrongly, or cleared too early. A clock edge would then reach the core one cycle after the bad state, as a stray rise or fall pulse. The serial output enable would show the wrong value on that same cycle. The shifted bytes would come out rotated by one bit by the end of the byte. If the pause state failed to clear on deselect, the output enable would stay low through the whole next transfer, and that transfer's first bit would already be wrong. The bench pairs cycle-exact vector checks of the pulses and the enable with full byte exchanges through a small shift-register core. Pauses are placed at the first, a middle and the last bit, and one transfer is aborted during a pause.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef enum logic {
      HS_RUN   = 1'b0,
      HS_PAUSE = 1'b1
   } hold_state_t;
endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   output logic sck_rise_o,
   output logic sck_fall_o,
   output logic cs_rise_o
);
   logic sck_q;
   logic cs_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         cs_n_q <= 1'b1;
      end else begin
         sck_q  <= sck_i;
         cs_n_q <= cs_n_i;
      end
   end

   assign sck_rise_o = sck_i & ~sck_q;
   assign sck_fall_o = ~sck_i & sck_q;
   assign cs_rise_o  = cs_n_i & ~cs_n_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sck_i,
   input  logic hold_n_i,
   output logic held_o,
   output logic held_nx_o
);
   hold_state_t st_q, st_nx;

   always_comb begin
      st_nx = st_q;
      if (cs_n_i) begin
         st_nx = HS_RUN;
      end else if (!sck_i) begin
         if (st_q == HS_RUN && !hold_n_i) begin
            st_nx = HS_PAUSE;
         end else if (st_q == HS_PAUSE && hold_n_i) begin
            st_nx = HS_RUN;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= HS_RUN;
      else        st_q <= st_nx;
   end

   assign held_o    = (st_q == HS_PAUSE);
   assign held_nx_o = (st_nx == HS_PAUSE);

   // R3 / R4: a pause only begins in a selected, clock-low cycle with hold low
   assert_enter_sck_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held_o) |-> $past(!sck_i && !cs_n_i && !hold_n_i))
      else $error("pause entered outside a clock-low selected cycle");

   // R6 / R8: a pause ends on a clock-low release or on deselect
   assert_exit_sck_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(held_o) |-> $past(cs_n_i || (hold_n_i && !sck_i)))
      else $error("pause released while clock high");
endmodule

// File: rtl/spi_hold_so.sv
module spi_hold_so #(
   parameter int unsigned IO_W   = 1,
   parameter bit          REG_SO = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IO_W-1:0] so_data_i,
   input  logic            so_en_i,
   input  logic            cs_n_i,
   input  logic            held_i,
   input  logic            held_nx_i,
   output logic [IO_W-1:0] so_o,
   output logic            so_oe_o
);
   generate
      if (REG_SO) begin : g_reg
         logic [IO_W-1:0] so_q;
         logic            oe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               so_q <= '0;
               oe_q <= 1'b0;
            end else begin
               if (!held_i && !held_nx_i) so_q <= so_data_i;
               oe_q <= so_en_i & ~cs_n_i & ~held_nx_i;
            end
         end
         assign so_o    = so_q;
         assign so_oe_o = oe_q;
      end else begin : g_comb
         assign so_o    = so_data_i;
         assign so_oe_o = so_en_i & ~cs_n_i & ~held_i;
      end
   endgenerate

   // R3: the pad is never driven while the pause is active
   assert_float_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      held_i |-> !so_oe_o)
      else $error("serial output driven during pause");
endmodule

// File: rtl/spi_hold_rst.sv
module spi_hold_rst #(
   parameter int unsigned RST_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_rise_i,
   output logic core_rst_o
);
   localparam int unsigned CW = $clog2(RST_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cs_rise_i) begin
         cnt_q <= CW'(RST_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign core_rst_o = (cnt_q != '0);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
   parameter int unsigned IO_W       = 1,
   parameter bit          REG_SO     = 1'b1,
   parameter int unsigned RST_CYCLES = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n_i,
   input  logic            sck_i,
   input  logic [IO_W-1:0] si_i,
   input  logic            hold_n_i,
   input  logic [IO_W-1:0] core_so_i,
   input  logic            core_so_oe_i,
   output logic            core_sck_rise_o,
   output logic            core_sck_fall_o,
   output logic [IO_W-1:0] core_si_o,
   output logic [IO_W-1:0] so_o,
   output logic            so_oe_o,
   output logic            core_rst_o
);
   generate
      if (IO_W < 1) begin : g_bad_width
         $error("IO_W must be at least 1");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic sck_rise, sck_fall, cs_rise;
   logic held, held_nx;
   logic pass;

   spi_hold_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_i      (sck_i),
      .cs_n_i     (cs_n_i),
      .sck_rise_o (sck_rise),
      .sck_fall_o (sck_fall),
      .cs_rise_o  (cs_rise)
   );

   spi_hold_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_i    (cs_n_i),
      .sck_i     (sck_i),
      .hold_n_i  (hold_n_i),
      .held_o    (held),
      .held_nx_o (held_nx)
   );

   spi_hold_so #(.IO_W(IO_W), .REG_SO(REG_SO)) u_so (
      .clk       (clk),
      .rst_n     (rst_n),
      .so_data_i (core_so_i),
      .so_en_i   (core_so_oe_i),
      .cs_n_i    (cs_n_i),
      .held_i    (held),
      .held_nx_i (held_nx),
      .so_o      (so_o),
      .so_oe_o   (so_oe_o)
   );

   spi_hold_rst #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_rise_i  (cs_rise),
      .core_rst_o (core_rst_o)
   );

   assign pass = ~cs_n_i & ~held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_sck_rise_o <= 1'b0;
         core_sck_fall_o <= 1'b0;
         core_si_o       <= '0;
      end else begin
         core_sck_rise_o <= sck_rise & pass;
         core_sck_fall_o <= sck_fall & pass;
         if (sck_rise && pass) core_si_o <= si_i;
      end
   end

   // R2: rise and fall pulses never overlap
   assert_edge_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(core_sck_rise_o && core_sck_fall_o))
      else $error("rise and fall pulses together");

   // R5: the sampled serial input is frozen across a paused cycle
   assert_si_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> $stable(core_si_o) && !core_sck_rise_o)
      else $error("serial input moved during pause");

   // R8: a core reset pulse always begins with the pause cleared
   assert_rst_clears_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_o) |-> !held)
      else $error("pause survived deselect");
endmodule

// File: tb/sim_spi_hold_gate.sv
module sim_spi_hold_gate;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cs_n, sck, si, hold_n;
   logic       man_so, man_oe, use_model;
   logic       core_so, core_oe;
   logic       c_rise, c_fall, c_si, so, so_oe, c_rst;

   int errors = 0;
   int checks = 0;

   // bench-side serial core: shifts in on rise pulses, out on fall pulses
   logic [7:0] rx, tx, tx_load;
   logic       mdl_load;
   int         rise_cnt;

   always #5 clk = ~clk;

   spi_hold_gate u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .cs_n_i          (cs_n),
      .sck_i           (sck),
      .si_i            (si),
      .hold_n_i        (hold_n),
      .core_so_i       (core_so),
      .core_so_oe_i    (core_oe),
      .core_sck_rise_o (c_rise),
      .core_sck_fall_o (c_fall),
      .core_si_o       (c_si),
      .so_o            (so),
      .so_oe_o         (so_oe),
      .core_rst_o      (c_rst)
   );

   assign core_so = use_model ? tx[7] : man_so;
   assign core_oe = use_model ? 1'b1  : man_oe;

   always @(posedge clk) begin
      if (c_rst || mdl_load) begin
         rx <= 8'h00;
         tx <= tx_load;
      end else begin
         if (c_rise) rx <= {rx[6:0], c_si};
         if (c_fall) tx <= {tx[6:0], 1'b0};
      end
      if (c_rise) rise_cnt <= rise_cnt + 1;
   end

   // {cs_n, sck, si, hold_n} -> expected {rise, fall, core_si, so_oe, core_rst}
   localparam logic [8:0] VEC [0:22] = '{
      9'b0001_00010, // R2 selected, idle
      9'b0111_10110, // R2 rise, SI=1 captured
      9'b0101_00110,
      9'b0001_01110, // R2 fall
      9'b0100_10010, // R4 hold low with clock high: ignored, rise passes
      9'b0000_01000, // R3 clock low: pause starts, fall already in flight
      9'b0110_00000, // R5 rise ignored
      9'b0010_00000, // R5 fall ignored
      9'b0111_00000, // R4 release with clock high: ignored
      9'b0011_00010, // R6 release with clock low
      9'b0111_10110, // R7 next rise reaches core
      9'b0000_01100, // R3 pause again
      9'b1000_00101, // R8 deselect in pause: reset pulse
      9'b1111_00100, // R9 no rise while deselected
      9'b1001_00100, // R9 no fall while deselected
      9'b0001_00110,
      9'b0000_00100, // R3 pause with clock idle low
      9'b0001_00110, // R6 release
      9'b1001_00101, // R8 plain deselect pulse
      9'b1000_00100, // R3 hold low while deselected: no pause
      9'b0000_00100, // R3 pause starts as select falls
      9'b0001_00110,
      9'b1001_00101  // R8
   };

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_core(input logic [7:0] v);
      tx_load  = v;
      mdl_load = 1'b1;
      wait_clk(1);
      mdl_load = 1'b0;
   endtask

   // one byte, MSB first; optional pause at bit hold_at, optional abort inside it
   task automatic run_byte(input logic [7:0] mosi, input int hold_at,
                           input bit abort, output logic [7:0] miso);
      logic pre;
      int   rc;
      miso = 8'h00;
      for (int b = 7; b >= 0; b--) begin
         sck = 1'b0;
         si  = mosi[b];
         wait_clk(4);
         if (b == hold_at) begin
            pre    = so;
            rc     = rise_cnt;
            hold_n = 1'b0;
            wait_clk(3);
            check("R3", "so_oe in pause", so_oe, 0);
            for (int k = 0; k < 3; k++) begin
               sck = 1'b1; si = ~si;
               wait_clk(4);
               check("R3", "so_oe in pause, clock high", so_oe, 0);
               sck = 1'b0; si = ~si;
               wait_clk(4);
            end
            check("R5", "rise pulses during pause", rise_cnt, rc);
            if (abort) begin
               cs_n = 1'b1;
               wait_clk(1);
               check("R8", "reset pulse on deselect", c_rst, 1);
               check("R9", "so_oe when deselected", so_oe, 0);
               wait_clk(1);
               check("R8", "reset pulse length", c_rst, 0);
               hold_n = 1'b1;
               return;
            end
            si     = mosi[b];
            hold_n = 1'b1;
            wait_clk(1);
            check("R6", "so_oe after release", so_oe, 1);
            check("R7", "so bit after release", so, pre);
            wait_clk(3);
         end
         miso[b] = so;
         sck = 1'b1;
         wait_clk(4);
      end
      sck = 1'b0;
      wait_clk(4);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] got;
      rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
      man_so = 1'b0; man_oe = 1'b1; use_model = 1'b0;
      mdl_load = 1'b0; tx_load = 8'h00; rise_cnt = 0;
      wait_clk(3);
      // R1 reset state
      check("R1", "rise in reset", c_rise, 0);
      check("R1", "fall in reset", c_fall, 0);
      check("R1", "si in reset", c_si, 0);
      check("R1", "so_oe in reset", so_oe, 0);
      check("R1", "core_rst in reset", c_rst, 0);
      rst_n = 1'b1;

      for (int i = 0; i < 23; i++) begin
         cs_n = VEC[i][8]; sck = VEC[i][7]; si = VEC[i][6]; hold_n = VEC[i][5];
         wait_clk(1);
         check("R2", $sformatf("vec %0d rise", i), c_rise, VEC[i][4]);
         check("R2", $sformatf("vec %0d fall", i), c_fall, VEC[i][3]);
         check("R5", $sformatf("vec %0d core_si", i), c_si, VEC[i][2]);
         check("R3", $sformatf("vec %0d so_oe", i), so_oe, VEC[i][1]);
         check("R8", $sformatf("vec %0d core_rst", i), c_rst, VEC[i][0]);
      end

      use_model = 1'b1;
      sck = 1'b0; hold_n = 1'b1; cs_n = 1'b1;
      wait_clk(4);

      // R2 plain byte exchange
      load_core(8'h3C);
      cs_n = 1'b0; wait_clk(4);
      run_byte(8'hA5, -1, 1'b0, got);
      check("R2", "core received byte", rx, 8'hA5);
      check("R2", "master received byte", got, 8'h3C);
      cs_n = 1'b1; wait_clk(4);

      // R7 pause in the middle of the byte
      load_core(8'hC3);
      cs_n = 1'b0; wait_clk(4);
      run_byte(8'h5A, 4, 1'b0, got);
      check("R7", "core byte, mid pause", rx, 8'h5A);
      check("R7", "master byte, mid pause", got, 8'hC3);
      cs_n = 1'b1; wait_clk(4);

      // R7 pause before the first and before the last bit
      load_core(8'h7E);
      cs_n = 1'b0; wait_clk(4);
      run_byte(8'h81, 7, 1'b0, got);
      check("R7", "core byte, first-bit pause", rx, 8'h81);
      check("R7", "master byte, first-bit pause", got, 8'h7E);
      cs_n = 1'b1; wait_clk(4);
      load_core(8'h96);
      cs_n = 1'b0; wait_clk(4);
      run_byte(8'h2D, 0, 1'b0, got);
      check("R7", "core byte, last-bit pause", rx, 8'h2D);
      check("R7", "master byte, last-bit pause", got, 8'h96);
      cs_n = 1'b1; wait_clk(4);

      // R8 abort during pause, then a fresh transfer from bit 0
      load_core(8'h99);
      cs_n = 1'b0; wait_clk(4);
      run_byte(8'hF0, 5, 1'b1, got);
      sck = 1'b0; wait_clk(4);
      cs_n = 1'b0; wait_clk(4);
      check("R8", "so_oe on new select", so_oe, 1);
      run_byte(8'h0F, -1, 1'b0, got);
      check("R8", "core byte after abort", rx, 8'h0F);
      check("R8", "master byte after abort", got, 8'h99);
      cs_n = 1'b1; wait_clk(2);
      check("R9", "so_oe after deselect", so_oe, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule